// File: doc/BRIEF.md
# Selectable-Mode Mantissa Rounding Unit

This unit takes an extended-precision significand, a sign and an exponent. It rounds the significand to one of three result precisions, using one of four rounding directions. The significand input has a few guard bits below the 64-bit field. The unit returns the rounded significand, left aligned, with every bit below the kept precision forced to zero. When the increment carries out of the top, the unit renormalises the result and raises the exponent by one. It also reports whether the result is inexact, and whether rounding increased the magnitude. That last indication is the one a condition-code bit takes.

The mode comes from a 16-bit control word held inside the unit. The unit decodes only the rounding field (bits 11:10) and the precision field (bits 9:8). Each operand is presented with a valid strobe, and its result appears one clock later. The unit does no overflow or underflow checking on the exponent and produces no denormals. It only passes the carry-out through.

Top module: `mant_rounder`

## Requirements
- R1: While reset is active and after it is released, `out_valid_o`, `sig_o`, `exp_o`, `carry_o`, `inexact_o` and `rnd_up_o` are zero. The control word resets to 0x037F, which gives nearest-even rounding at 64-bit precision.
- R2: When `cw_we_i` is high at a clock edge, `cw_i` replaces the control word. Operands sampled at any later edge are rounded under the new word.
- R3: An operand sampled with `in_valid_i` high produces its results, with `out_valid_o` high, exactly one clock later. In a cycle with no operand, `out_valid_o` is low and the result outputs hold their values.
- R4: Precision field bits 9:8 select the kept significand bits: 00 keeps 24, 10 keeps 53, 11 keeps 64, and the reserved code 01 also keeps 64. The bits of `sig_o` below the kept width are zero.
- R5: Rounding field 00 selects nearest-even. A discarded part above half an LSB rounds up and one below half rounds down. An exact half rounds to the candidate whose LSB is zero.
- R6: Rounding field 01 rounds toward minus infinity: the magnitude is incremented only for a negative operand with a nonzero discarded part.
- R7: Rounding field 10 rounds toward plus infinity: the magnitude is incremented only for a positive operand with a nonzero discarded part.
- R8: Rounding field 11 truncates: the magnitude is never incremented.
- R9: `inexact_o` is high exactly when a discarded bit is nonzero. The discarded bits include the guard bits.
- R10: `rnd_up_o` is high exactly when rounding increased the magnitude.
- R11: When the increment overflows the kept width, `carry_o` is high, `sig_o` is 0x8000_0000_0000_0000 and `exp_o` equals the input exponent plus one. Otherwise `exp_o` equals the input exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_we_i | input | 1 | Control-word write strobe |
| cw_i | input | 16 | Control-word value to load |
| in_valid_i | input | 1 | Operand valid |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | 15 | Operand exponent |
| sig_i | input | 72 | Significand: 64 bits plus 8 guard bits |
| out_valid_o | output | 1 | Result valid |
| sig_o | output | 64 | Rounded significand, left aligned |
| exp_o | output | 15 | Exponent after carry adjustment |
| carry_o | output | 1 | Increment overflowed; renormalised |
| inexact_o | output | 1 | Discarded bits were nonzero |
| rnd_up_o | output | 1 | Magnitude was increased |

## Verification
Every result, including the two flags and the exponent adjustment, is registered once, so each is due on the clock edge that follows the one that sampled the operand. The bench drives each operand at a falling edge and lets one rising edge pass. It compares all outputs at the next falling edge, away from any edge where they change. A control-word write is given its own cycle before the operands that depend on it. An idle cycle is checked to show that the valid flag drops and the result outputs hold.

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int SIG_W = 64,
  parameter int GRD_W = 8,
  parameter int EXP_W = 15,
  parameter logic [15:0] CW_RESET = 16'h037F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_we_i,
  input  logic [15:0]      cw_i,
  input  logic             in_valid_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W+GRD_W-1:0] sig_i,
  output logic             out_valid_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             carry_o,
  output logic             inexact_o,
  output logic             rnd_up_o
);
  localparam int W     = SIG_W + GRD_W;
  localparam int P_SGL = 24;
  localparam int P_DBL = 53;
  localparam int SH_W  = $clog2(W + 1);

  logic [15:0]   cw_q;
  logic [1:0]    rc, pc;
  int unsigned   keep_n;
  logic [SH_W-1:0] cut;
  logic [W-1:0]  lsb_unit, half_unit, disc_mask, disc;
  logic          inexact, lsb_set, gt_half, eq_half, bump, carry;
  logic [W:0]    sum;
  logic [W-1:0]  norm;

  assign rc = cw_q[11:10];
  assign pc = cw_q[9:8];

  always_comb begin
    case (pc)
      2'b00:   keep_n = P_SGL;
      2'b10:   keep_n = P_DBL;
      default: keep_n = SIG_W;
    endcase
  end

  assign cut       = SH_W'(W - keep_n);
  assign lsb_unit  = W'(1) << cut;
  assign half_unit = lsb_unit >> 1;
  assign disc_mask = lsb_unit - W'(1);
  assign disc      = sig_i & disc_mask;
  assign inexact   = |disc;
  assign lsb_set   = |(sig_i & lsb_unit);
  assign gt_half   = disc > half_unit;
  assign eq_half   = disc == half_unit;

  always_comb begin
    case (rc)
      2'b00:   bump = gt_half | (eq_half & lsb_set);
      2'b01:   bump = inexact & sign_i;
      2'b10:   bump = inexact & ~sign_i;
      default: bump = 1'b0;
    endcase
  end

  assign sum   = {1'b0, sig_i & ~disc_mask} + (bump ? {1'b0, lsb_unit} : '0);
  assign carry = sum[W];
  assign norm  = carry ? sum[W:1] : sum[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q        <= CW_RESET;
      out_valid_o <= 1'b0;
      sig_o       <= '0;
      exp_o       <= '0;
      carry_o     <= 1'b0;
      inexact_o   <= 1'b0;
      rnd_up_o    <= 1'b0;
    end else begin
      if (cw_we_i) cw_q <= cw_i;
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sig_o     <= norm[W-1 -: SIG_W];
        exp_o     <= exp_i + EXP_W'(carry);
        carry_o   <= carry;
        inexact_o <= inexact;
        rnd_up_o  <= bump;
      end
    end
  end

  p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!out_valid_o && $stable(sig_o) && $stable(rnd_up_o)));
  p_carry_norm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (sig_o == {1'b1, {(SIG_W-1){1'b0}}} && rnd_up_o));
  p_up_needs_inexact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_up_o |-> inexact_o);
  p_trunc_no_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && $past(cw_q[11:10]) == 2'b11) |-> !rnd_up_o);
  p_minus_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && $past(cw_q[11:10]) == 2'b01 && !$past(sign_i)) |-> !rnd_up_o);
  p_plus_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && $past(cw_q[11:10]) == 2'b10 && $past(sign_i)) |-> !rnd_up_o);
  p_single_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && $past(cw_q[9:8]) == 2'b00) |-> (sig_o[SIG_W-P_SGL-1:0] == '0));
endmodule

// File: tb/mant_rounder_test.sv
module mant_rounder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_we_i = 1'b0;
  logic [15:0] cw_i = '0;
  logic        in_valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [14:0] exp_i = '0;
  logic [71:0] sig_i = '0;
  logic        out_valid_o;
  logic [63:0] sig_o;
  logic [14:0] exp_o;
  logic        carry_o, inexact_o, rnd_up_o;

  int vectors = 0;
  int fails = 0;
  logic finished = 1'b0;
  logic [15:0] cw_model = 16'h037F;

  always #10 clk = ~clk;

  mant_rounder uut (
    .clk(clk), .rst_n(rst_n), .cw_we_i(cw_we_i), .cw_i(cw_i),
    .in_valid_i(in_valid_i), .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
    .out_valid_o(out_valid_o), .sig_o(sig_o), .exp_o(exp_o),
    .carry_o(carry_o), .inexact_o(inexact_o), .rnd_up_o(rnd_up_o)
  );

  function automatic void model(input logic sg, input logic [71:0] x, input logic [14:0] e,
                                input logic [15:0] cw, output logic [63:0] so,
                                output logic [14:0] eo, output logic co,
                                output logic ix, output logic up);
    int p;
    int s;
    logic [72:0] kept, rem, half, res;
    logic inc;
    case (cw[9:8])
      2'b00:   p = 24;
      2'b10:   p = 53;
      default: p = 64;
    endcase
    s    = 72 - p;
    kept = 73'(x) >> s;
    rem  = 73'(x) - (kept << s);
    half = 73'(1) << (s - 1);
    ix   = (rem != 0);
    case (cw[11:10])
      2'b00:   inc = (rem > half) || ((rem == half) && kept[0]);
      2'b01:   inc = ix && sg;
      2'b10:   inc = ix && !sg;
      default: inc = 1'b0;
    endcase
    res = kept + 73'(inc);
    co  = (res == (73'(1) << p));
    if (co) res = res >> 1;
    eo  = e + 15'(co);
    so  = 64'(res << (64 - p));
    up  = inc;
  endfunction

  task automatic check1(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_cw(input logic [15:0] v);
    cw_we_i = 1'b1;
    cw_i = v;
    @(posedge clk);
    @(negedge clk);
    cw_we_i = 1'b0;
    cw_model = v;
  endtask

  task automatic run_vec(input logic sg, input logic [71:0] x, input logic [14:0] e);
    logic [63:0] so;
    logic [14:0] eo;
    logic co, ix, up;
    string mtag;
    model(sg, x, e, cw_model, so, eo, co, ix, up);
    case (cw_model[11:10])
      2'b00:   mtag = "R5 nearest";
      2'b01:   mtag = "R6 minus";
      2'b10:   mtag = "R7 plus";
      default: mtag = "R8 trunc";
    endcase
    in_valid_i = 1'b1;
    sign_i = sg;
    sig_i = x;
    exp_i = e;
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    check1("R3 valid", 64'(out_valid_o), 64'd1);
    check1({mtag, " R4 sig"}, sig_o, so);
    check1("R9 inexact", 64'(inexact_o), 64'(ix));
    check1("R10 rnd_up", 64'(rnd_up_o), 64'(up));
    check1("R11 carry", 64'(carry_o), 64'(co));
    check1("R11 exp", 64'(exp_o), 64'(eo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check1("R1 reset valid", 64'(out_valid_o), 64'd0);
    check1("R1 reset sig", sig_o, 64'd0);
    check1("R1 reset flags", 64'({carry_o, inexact_o, rnd_up_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R1 after release", 64'({out_valid_o, exp_o}), 64'd0);

    // R1: default word rounds a tie with odd LSB up at 64-bit precision
    run_vec(1'b0, {64'h8000_0000_0000_0001, 8'h80}, 15'h3FFF);
    check1("R1 default nearest 64", sig_o, 64'h8000_0000_0000_0002);

    // R3: idle cycle drops valid and holds outputs
    held = sig_o;
    @(negedge clk);
    check1("R3 idle valid", 64'(out_valid_o), 64'd0);
    check1("R3 idle hold", sig_o, held);

    // R2: new word applies to the next operand
    write_cw(16'h0F7F);
    run_vec(1'b0, {64'h8000_0000_0000_0001, 8'hC0}, 15'h0100);
    check1("R2 truncate after write", 64'(rnd_up_o), 64'd0);

    // R4: reserved precision code behaves as 64 bits
    write_cw(16'h017F);
    run_vec(1'b0, {64'h8000_0000_0000_0003, 8'h00}, 15'h0010);
    check1("R4 reserved code keeps 64", sig_o, 64'h8000_0000_0000_0003);

    // R11: carry renormalises and bumps exponent
    write_cw(16'h037F);
    run_vec(1'b1, {64'hFFFF_FFFF_FFFF_FFFF, 8'hFF}, 15'h1234);
    check1("R11 carry sig", sig_o, 64'h8000_0000_0000_0000);
    check1("R11 carry exp", 64'(exp_o), 64'h1235);

    // Sweep: precision x mode x sign x kept pattern x discarded pattern
    for (int pcode = 0; pcode < 4; pcode++) begin
      for (int rcode = 0; rcode < 4; rcode++) begin
        write_cw({4'h0, 2'(rcode), 2'(pcode), 8'h7F});
        for (int sg = 0; sg < 2; sg++) begin
          for (int kc = 0; kc < 3; kc++) begin
            for (int rcl = 0; rcl < 6; rcl++) begin
              int p;
              int s;
              logic [72:0] kept, rem, half;
              p = (pcode == 0) ? 24 : (pcode == 2) ? 53 : 64;
              s = 72 - p;
              half = 73'(1) << (s - 1);
              case (kc)
                0:       kept = 73'(1) << (p - 1);
                1:       kept = (73'(1) << (p - 1)) | 73'(1);
                default: kept = (73'(1) << p) - 73'(1);
              endcase
              case (rcl)
                0:       rem = '0;
                1:       rem = 73'(1);
                2:       rem = half - 73'(1);
                3:       rem = half;
                4:       rem = half + 73'(1);
                default: rem = (73'(1) << s) - 73'(1);
              endcase
              run_vec(sg[0], 72'((kept << s) | rem), 15'(16'h3FF0 + kc * 6 + rcl));
            end
          end
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule